// File: doc/BRIEF.md
# Sample Record/Playback Address Controller

This block sequences a RAM-based sample recorder. A binary address counter walks through memory once per sample period, which a one-cycle `sampleTick` marks. In record mode the converter's output enable is on and the RAM receives a write strobe for each sample. In play mode the converter output is released, the RAM is read, and a load strobe tells the DAC when to capture the word. The strobe comes a fixed number of clock cycles after each tick, and the address stays stable around it. Once the strobe has been issued, the counter advances.

Three push buttons control a run. Start begins a run, or resumes one that was paused. Pause freezes the address. Stop ends the run and returns the address to zero. The top counter bit acts as the terminal-count flag. In one-pass operation that flag ends the run. In continuous playback it wraps the counter back to the start of its region.

In key mode a key code takes over the upper address bits, which splits memory into equal sectors, one per note. The counter then spans only a single sector.

Top module: `recPlayCtl`

## Requirements
- R1: After reset the block is idle: `running`, `ramWe`, `dacLoad` and `recLamp` are 0 and `memAddr` is 0.
- R2: A start press while idle and not paused sets `running` on the next cycle. The first sample slot then uses address 0. Each later slot uses the previous address plus one, with one slot per `sampleTick` seen while running.
- R3: A slot (a `ramWe` or `dacLoad` pulse of one cycle) is asserted exactly STROBE_DLY clock cycles after the cycle in which `sampleTick` was high. `memAddr` holds the same value in the slot cycle and in the cycle before it.
- R4: Record mode is `playMode`=0. In this mode `adcOe`=1, `ramOe`=0 and `dacEn`=0. Each slot pulses `ramWe` and never `dacLoad`, and `recLamp` is 1 while running.
- R5: Play mode is `playMode`=1. In this mode `adcOe`=0, `ramOe`=1 and `dacEn`=1. Each slot pulses `dacLoad` and never `ramWe`.
- R6: With `keyMode`=0 the counter is ADDR_W bits wide. `memAddr` carries its low ADDR_W-1 bits, and the top bit of `memAddr` is 0. A one-pass run ends when counter bit ADDR_W-1 sets, which is after 2^(ADDR_W-1) slots. The block is then idle with the address at zero.
- R7: With `loopMode`=1 in play mode, the address wraps to its region start after the last slot, and the run continues until stop. In record mode `loopMode` is ignored, so a run still makes exactly one pass.
- R8: A pause press while running stops further slots and holds `memAddr`. A later start resumes from the held address.
- R9: A stop press ends the run and clears the address to zero. Stop takes priority over pause and start, and the next start begins at address 0.
- R10: With `keyMode`=1, `memAddr` is {`keyCode`, low ADDR_W-KEY_W counter bits}. A run lasts 2^(ADDR_W-KEY_W) slots, and continuous play wraps to address `keyCode`·2^(ADDR_W-KEY_W).
- R11: A start press while running is ignored: the slot count and address sequence of the run do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle pulse per sample period |
| startBtn | input | 1 | Start/resume request, one-cycle pulse |
| pauseBtn | input | 1 | Pause request, one-cycle pulse |
| stopBtn | input | 1 | Stop request, one-cycle pulse |
| playMode | input | 1 | 1 = play, 0 = record |
| loopMode | input | 1 | 1 = continuous replay, 0 = single pass |
| keyMode | input | 1 | 1 = key code selects the sector |
| keyCode | input | KEY_W | Sector number in key mode |
| memAddr | output | ADDR_W | RAM address |
| adcOe | output | 1 | Converter output enable (record) |
| ramOe | output | 1 | RAM read enable (play) |
| ramWe | output | 1 | RAM write strobe, one cycle per slot |
| dacEn | output | 1 | DAC enable (play) |
| dacLoad | output | 1 | DAC load strobe, one cycle per slot |
| recLamp | output | 1 | Recording indicator |
| running | output | 1 | Run in progress |

## Verification
The bench goes after the terminal boundary in three ways:
- A design that leaves out the last address, or writes one past it, shows a wrong slot count or a bad final address.
- Wrapping in continuous play is checked, both to zero and to a sector base. A wrap to the wrong base shows up as a broken address series.
- Record mode with looping set must still stop after one pass.

Pause and stop are checked against each other. A pause that clears the address, or a stop that only freezes it, gives a wrong resume address. The bench also measures the strobe's distance from every tick and checks that the address is stable. A design that advances before the strobe, or strobes on the tick itself, fails that check. Every one of the eight sectors is swept, so a swapped or shifted key field is caught.

// File: rtl/recPlayPkg.sv
package recPlayPkg;
  // Counter commands from control to datapath
  typedef struct packed {
    logic clr;  // return counter to region start
    logic inc;  // advance after a sample slot
  } cntCmd_t;
endpackage

// File: rtl/recPlayDatapath.sv
module recPlayDatapath
  import recPlayPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int KEY_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntCmd_t           cmd,
  input  logic              keyMode,
  input  logic [KEY_W-1:0]  keyCode,
  output logic              termHit,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int LOW_W = ADDR_W - KEY_W;  // sector-local bits
  localparam int REC_W = ADDR_W - 1;      // full-memory bits

  logic [ADDR_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN)        cntQ <= '0;
    else if (cmd.clr) cntQ <= '0;
    else if (cmd.inc) cntQ <= cntQ + ADDR_W'(1);
  end

  // terminal flag: bit just above the active address range
  always_comb begin
    termHit = keyMode ? cntQ[LOW_W] : cntQ[ADDR_W-1];
    if (keyMode) memAddr = {keyCode, cntQ[LOW_W-1:0]};
    else         memAddr = {1'b0, cntQ[REC_W-1:0]};
  end

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.inc |-> $stable(cntQ));

  // R6
  term_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    termHit |=> (cntQ == '0));
endmodule

// File: rtl/recPlayCtrl.sv
module recPlayCtrl
  import recPlayPkg::*;
#(
  parameter int STROBE_DLY = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleTick,
  input  logic    startBtn,
  input  logic    pauseBtn,
  input  logic    stopBtn,
  input  logic    playMode,
  input  logic    loopMode,
  input  logic    termHit,
  output cntCmd_t cmd,
  output logic    running,
  output logic    adcOe,
  output logic    ramOe,
  output logic    ramWe,
  output logic    dacEn,
  output logic    dacLoad,
  output logic    recLamp
);
  localparam int DLY_W = $clog2(STROBE_DLY + 1);

  logic             runQ, pausedQ, armedQ;
  logic [DLY_W-1:0] dlyQ;
  logic             slot, keepGoing;

  assign slot      = runQ && armedQ && (dlyQ == '0);
  assign keepGoing = loopMode && playMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0; pausedQ <= 1'b0; armedQ <= 1'b0; dlyQ <= '0;
    end else if (stopBtn) begin
      runQ <= 1'b0; pausedQ <= 1'b0; armedQ <= 1'b0;
    end else if (termHit) begin
      armedQ <= 1'b0; pausedQ <= 1'b0;
      if (!keepGoing) runQ <= 1'b0;
    end else if (pauseBtn && runQ) begin
      runQ <= 1'b0; pausedQ <= 1'b1; armedQ <= 1'b0;
    end else if (startBtn && !runQ) begin
      runQ <= 1'b1; pausedQ <= 1'b0;
    end else if (slot) begin
      armedQ <= 1'b0;
    end else if (sampleTick && runQ) begin
      armedQ <= 1'b1; dlyQ <= DLY_W'(STROBE_DLY - 1);
    end else if (armedQ && dlyQ != '0) begin
      dlyQ <= dlyQ - DLY_W'(1);
    end
  end

  always_comb begin
    cmd.clr = stopBtn || termHit;
    cmd.inc = slot;
    running = runQ;
    adcOe   = !playMode;
    ramOe   = playMode;
    dacEn   = playMode;
    ramWe   = slot && !playMode;
    dacLoad = slot && playMode;
    recLamp = runQ && !playMode;
  end

  // R7
  oneshot_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termHit && !(loopMode && playMode)) |=> !running);

  // R9
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopBtn |=> (!running && !ramWe && !dacLoad));

  // R8
  pause_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pauseBtn && !termHit) |=> !running);

  // R4
  we_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (!playMode && running));
endmodule

// File: rtl/recPlayCtl.sv
module recPlayCtl
  import recPlayPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int KEY_W      = 3,
  parameter int STROBE_DLY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              startBtn,
  input  logic              pauseBtn,
  input  logic              stopBtn,
  input  logic              playMode,
  input  logic              loopMode,
  input  logic              keyMode,
  input  logic [KEY_W-1:0]  keyCode,
  output logic [ADDR_W-1:0] memAddr,
  output logic              adcOe,
  output logic              ramOe,
  output logic              ramWe,
  output logic              dacEn,
  output logic              dacLoad,
  output logic              recLamp,
  output logic              running
);
  cntCmd_t cmd;
  logic    termHit;

  recPlayCtrl #(.STROBE_DLY(STROBE_DLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .startBtn(startBtn), .pauseBtn(pauseBtn), .stopBtn(stopBtn),
    .playMode(playMode), .loopMode(loopMode), .termHit(termHit),
    .cmd(cmd), .running(running), .adcOe(adcOe), .ramOe(ramOe),
    .ramWe(ramWe), .dacEn(dacEn), .dacLoad(dacLoad), .recLamp(recLamp)
  );

  recPlayDatapath #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .keyMode(keyMode),
    .keyCode(keyCode), .termHit(termHit), .memAddr(memAddr)
  );
endmodule

// File: tb/recPlayCtl_tb.sv
module recPlayCtl_tb;
  localparam int ADDR_W = 6;
  localparam int KEY_W  = 3;
  localparam int DLY    = 3;
  localparam int FULL   = 1 << (ADDR_W - 1);     // 32 slots
  localparam int SECT   = 1 << (ADDR_W - KEY_W); // 8 slots

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0, startBtn = 1'b0, pauseBtn = 1'b0, stopBtn = 1'b0;
  logic playMode = 1'b0, loopMode = 1'b0, keyMode = 1'b0;
  logic [KEY_W-1:0]  keyCode = '0;
  logic [ADDR_W-1:0] memAddr;
  logic adcOe, ramOe, ramWe, dacEn, dacLoad, recLamp, running;

  int checks = 0, errors = 0;
  int slotN = 0;
  int slotAddr [0:255];
  int tickAge = 99;
  logic [ADDR_W-1:0] prevAddr = '0;

  always #10 clk = ~clk;

  recPlayCtl #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .STROBE_DLY(DLY)) u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .startBtn(startBtn),
    .pauseBtn(pauseBtn), .stopBtn(stopBtn), .playMode(playMode),
    .loopMode(loopMode), .keyMode(keyMode), .keyCode(keyCode),
    .memAddr(memAddr), .adcOe(adcOe), .ramOe(ramOe), .ramWe(ramWe),
    .dacEn(dacEn), .dacLoad(dacLoad), .recLamp(recLamp), .running(running)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  // sampling monitor, half a period from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleTick) tickAge = 0; else tickAge++;
      if (ramWe || dacLoad) begin
        chk(tickAge == DLY, "R3 strobe delay", tickAge, DLY);
        chk(memAddr == prevAddr, "R3 addr stable", memAddr, prevAddr);
        chk(!(ramWe && dacLoad), "R4/R5 single strobe", ramWe, 0);
        if (ramWe) chk(!playMode && adcOe && !ramOe && !dacEn, "R4 record enables", adcOe, 1);
        if (dacLoad) chk(playMode && ramOe && dacEn && !adcOe, "R5 play enables", ramOe, 1);
        if (slotN < 256) slotAddr[slotN] = int'(memAddr);
        slotN++;
      end
    end
    prevAddr = memAddr;
  end

  // sample clock: one tick every 8 cycles
  initial begin
    wait (rstN);
    forever begin
      repeat (7) step();
      sampleTick = 1'b1;
      step();
      sampleTick = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic press(input int which);
    if (which == 0) startBtn = 1'b1;
    else if (which == 1) pauseBtn = 1'b1;
    else stopBtn = 1'b1;
    step();
    startBtn = 1'b0; pauseBtn = 1'b0; stopBtn = 1'b0;
  endtask

  task automatic waitSlots(input int n);
    for (int i = 0; i < 5000 && slotN < n; i++) step();
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 5000 && running; i++) step();
  endtask

  task automatic chkSeq(input string tag, input int n, input int base, input int span);
    for (int k = 0; k < n; k++)
      chk(slotAddr[k] == base + (k % span), tag, slotAddr[k], base + (k % span));
  endtask

  task automatic begin_run(input logic play, input logic loop);
    playMode = play; loopMode = loop; slotN = 0;
    press(0);
    chk(running == 1'b1, "R2 start sets running", running, 1);
    chk(recLamp == !play, "R4 record lamp", recLamp, !play);
  endtask

  initial begin
    repeat (4) step();
    // R1 reset state
    chk(running == 1'b0, "R1 running", running, 0);
    chk(memAddr == '0, "R1 addr", memAddr, 0);
    chk(!ramWe && !dacLoad && !recLamp, "R1 strobes/lamp", recLamp, 0);
    rstN = 1'b1;
    step();

    // R2 R4 R6: record single pass
    begin_run(1'b0, 1'b0);
    waitIdle();
    chk(slotN == FULL, "R6 record slot count", slotN, FULL);
    chkSeq("R2 record addr", FULL, 0, FULL);
    chk(memAddr == '0 && !recLamp, "R6 idle at zero", memAddr, 0);

    // R5 R6: play single pass
    begin_run(1'b1, 1'b0);
    waitIdle();
    chk(slotN == FULL, "R6 play slot count", slotN, FULL);
    chkSeq("R5 play addr", FULL, 0, FULL);

    // R7: loop ignored in record
    begin_run(1'b0, 1'b1);
    waitIdle();
    chk(slotN == FULL, "R7 record ignores loop", slotN, FULL);

    // R7 R9: continuous play until stop
    begin_run(1'b1, 1'b1);
    waitSlots(70);
    press(2);
    step();
    chk(running == 1'b0, "R9 stop halts", running, 0);
    chk(memAddr == '0, "R9 stop clears addr", memAddr, 0);
    chk(slotN >= 70, "R7 loop continues", slotN, 70);
    chkSeq("R7 wrap addr", slotN, 0, FULL);

    // R8: pause and resume
    begin_run(1'b1, 1'b0);
    waitSlots(10);
    press(1);
    repeat (40) step();
    chk(slotN == 10, "R8 no slots while paused", slotN, 10);
    chk(memAddr == 10, "R8 addr held", memAddr, 10);
    chk(running == 1'b0, "R8 not running", running, 0);
    press(0);
    waitIdle();
    chk(slotN == FULL, "R8 resume count", slotN, FULL);
    chkSeq("R8 resume addr", FULL, 0, FULL);

    // R11: start during run ignored
    begin_run(1'b0, 1'b0);
    waitSlots(5);
    press(0);
    waitIdle();
    chk(slotN == FULL, "R11 start ignored count", slotN, FULL);
    chkSeq("R11 start ignored addr", FULL, 0, FULL);

    // R9: stop mid-run, then fresh start from zero
    begin_run(1'b1, 1'b0);
    waitSlots(12);
    press(2);
    chk(memAddr == '0 && !running, "R9 stop mid-run", memAddr, 0);
    begin_run(1'b1, 1'b0);
    waitIdle();
    chkSeq("R9 restart from zero", FULL, 0, FULL);
    chk(slotN == FULL, "R9 restart count", slotN, FULL);

    // R10: every sector, single-pass play
    keyMode = 1'b1;
    for (int key = 0; key < (1 << KEY_W); key++) begin
      keyCode = KEY_W'(key);
      begin_run(1'b1, 1'b0);
      waitIdle();
      chk(slotN == SECT, "R10 sector count", slotN, SECT);
      chkSeq("R10 sector addr", SECT, key * SECT, SECT);
      chk(memAddr == key * SECT, "R10 sector idle addr", memAddr, key * SECT);
    end
    // R10: record into sector 5
    keyCode = 3'd5;
    begin_run(1'b0, 1'b0);
    waitIdle();
    chk(slotN == SECT, "R10 record sector count", slotN, SECT);
    chkSeq("R10 record sector addr", SECT, 5 * SECT, SECT);
    // R10 R7: continuous in sector 3 wraps to sector base
    keyCode = 3'd3;
    begin_run(1'b1, 1'b1);
    waitSlots(20);
    press(2);
    chkSeq("R10 sector wrap addr", 20, 3 * SECT, SECT);
    chk(memAddr == 3 * SECT, "R10 stop to sector base", memAddr, 3 * SECT);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule